// File: doc/BRIEF.md
# Backplane Bus Master Cycle Sequencer

This block runs bus cycles for the permanent master of a 100-pin parallel backplane. A client presents a cycle kind, an address and, for writes, a data byte on a simple valid/ready request port. The block then runs the cycle on the backplane. It raises the cycle-start strobe together with the active-low address/status-valid strobe, asserts the read or the write strobe, and holds a one-hot status set for the whole cycle. It also derives the memory write strobe from the write strobe and the output status.

The slave paces the cycle through two ready inputs. While either input is low, the cycle stays in wait states. When the cycle closes, the block returns the captured read data with a one-clock completion pulse. A halt request leaves the halt status raised until an interrupt event arrives or reset is applied.

Top module: `bus_cycle_seq`

## Requirements
- R1: While `rst` is sampled high and in the cycle after, the outputs are idle: `psync`=0, `pstval_n`=1, `pdbin`=0, `pwr_n`=1, `mwrt`=0, every status output inactive (`s_wo_n`=1, the others 0), `bus_addr`=0, `bus_dout`=0, `rsp_done`=0 and `req_ready`=1.
- R2: A request is accepted when `req_valid` and `req_ready` are high at a clock edge and `req_kind` is 0 to 6. In the next clock (T1), `psync` is 1 and `pstval_n` is 0 for exactly that clock. `bus_addr` carries the request address from T1 until the cycle ends.
- R3: The status is held from T1 to the last clock of the cycle, according to `req_kind`. Kind 0 (memory read) sets `s_memr`. Kind 1 (opcode fetch) sets `s_memr` and `s_m1`. Kind 2 (memory write) sets `s_wo_n`=0. Kind 3 (I/O read) sets `s_inp`. Kind 4 (I/O write) sets `s_out` and `s_wo_n`=0. Kind 5 (interrupt acknowledge) sets `s_inta`. Kind 6 (halt) sets `s_hlta`.
- R4: From the clock after T1 (T2) to the last clock (T3), the strobe for the cycle is active. For kinds 0, 1, 3 and 5, `pdbin` is 1. For kinds 2 and 4, `pwr_n` is 0 and `bus_dout` carries the write data. `bus_dout` is 0 at every other time.
- R5: `bus_rdy` and `bus_xrdy` are sampled at the edge that ends T2 and at the edge that ends each wait clock. If either is low, one more wait clock follows with strobes and status held. The ready inputs have no effect in T1 or T3.
- R6: For read kinds, `bus_din` is captured at the edge that ends T3. In the next clock, `rsp_rdata` shows the captured value and `rsp_done` is 1 for one clock. `rsp_rdata` keeps its value across write, halt and idle clocks.
- R7: `mwrt` is 1 exactly while the write strobe is active and `s_out` is 0, so it is 1 only during memory write cycles.
- R8: A halt request runs T1 and then holds `s_hlta`=1 and `req_ready`=0 with no strobes. `intr_evt` is sampled only while halted. When it is sampled high, the next clock is idle with `rsp_done`=1 and `s_hlta`=0.
- R9: A request with `req_kind`=7 is ignored: the block stays idle, with no `psync`, no `rsp_done`, and `req_ready` still 1.
- R10: A new request can be accepted in the same clock in which `rsp_done` is 1. Its T1 follows at once, so consecutive cycles have a single idle clock between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Cycle kind code (see R3) |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Block idle, request may be accepted |
| intr_evt | input | 1 | Interrupt event that ends a halt |
| bus_rdy | input | 1 | Slave ready, first input |
| bus_xrdy | input | 1 | Slave ready, second input |
| bus_din | input | DATA_W | Read data from the bus |
| bus_addr | output | ADDR_W | Address to the bus |
| bus_dout | output | DATA_W | Write data to the bus |
| psync | output | 1 | Cycle-start strobe |
| pstval_n | output | 1 | Address/status-valid strobe, active low |
| pdbin | output | 1 | Read strobe |
| pwr_n | output | 1 | Write strobe, active low |
| mwrt | output | 1 | Memory write strobe |
| s_memr | output | 1 | Memory read status |
| s_m1 | output | 1 | Opcode fetch status |
| s_inp | output | 1 | I/O input status |
| s_out | output | 1 | I/O output status |
| s_inta | output | 1 | Interrupt acknowledge status |
| s_hlta | output | 1 | Halt status |
| s_wo_n | output | 1 | Write/output status, active low |
| rsp_done | output | 1 | Cycle complete pulse |
| rsp_rdata | output | DATA_W | Captured read data |

## Verification
Two overlaps need care. The first is the completion pulse of one cycle falling in the same clock that accepts the next request. The bench keeps its request queue full so that new requests are presented during `rsp_done`. The reference model then expects `psync` in the very next clock. The second is the ready inputs being pulled low in T1 and T3 while the cycle moves on. The bench drives ready low in those clocks on purpose, and the model requires that no wait clock appears.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        KIND_MEMRD = 3'd0,
        KIND_FETCH = 3'd1,
        KIND_MEMWR = 3'd2,
        KIND_IORD  = 3'd3,
        KIND_IOWR  = 3'd4,
        KIND_INTA  = 3'd5,
        KIND_HALT  = 3'd6,
        KIND_NONE  = 3'd7
    } cyc_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_TW   = 3'd3,
        PH_T3   = 3'd4,
        PH_HALT = 3'd5
    } cyc_phase_e;

    typedef struct packed {
        logic memr;
        logic m1;
        logic inp;
        logic outp;
        logic inta;
        logic hlta;
        logic wo;
    } bus_status_t;

    function automatic logic kind_reads(cyc_kind_e k);
        return (k == KIND_MEMRD) || (k == KIND_FETCH) ||
               (k == KIND_IORD)  || (k == KIND_INTA);
    endfunction

    function automatic logic kind_writes(cyc_kind_e k);
        return (k == KIND_MEMWR) || (k == KIND_IOWR);
    endfunction

    function automatic logic phase_strobed(cyc_phase_e p);
        return (p == PH_T2) || (p == PH_TW) || (p == PH_T3);
    endfunction

endpackage

// File: rtl/bcs_ready_qual.sv
module bcs_ready_qual #(
    parameter int N_RDY = 2
) (
    input  logic [N_RDY-1:0] rdy_in,
    output logic             all_rdy
);
    logic [N_RDY:0] chain;

    assign chain[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < N_RDY; gi++) begin : g_and
            assign chain[gi+1] = chain[gi] & rdy_in[gi];
        end
    endgenerate

    assign all_rdy = chain[N_RDY];
endmodule

// File: rtl/bcs_status_enc.sv
module bcs_status_enc
    import bcs_pkg::*;
(
    input  cyc_phase_e  phase,
    input  cyc_kind_e   kind,
    output bus_status_t status,
    output logic        rd_strobe,
    output logic        wr_strobe
);
    logic busy;

    always_comb begin
        busy      = (phase == PH_T1) || phase_strobed(phase);
        status    = '0;
        rd_strobe = phase_strobed(phase) && kind_reads(kind);
        wr_strobe = phase_strobed(phase) && kind_writes(kind);
        if (busy) begin
            unique case (kind)
                KIND_MEMRD: status.memr = 1'b1;
                KIND_FETCH: begin
                    status.memr = 1'b1;
                    status.m1   = 1'b1;
                end
                KIND_MEMWR: status.wo = 1'b1;
                KIND_IORD:  status.inp = 1'b1;
                KIND_IOWR: begin
                    status.outp = 1'b1;
                    status.wo   = 1'b1;
                end
                KIND_INTA:  status.inta = 1'b1;
                KIND_HALT:  status.hlta = 1'b1;
                default:    status = '0;
            endcase
        end
        if (phase == PH_HALT) begin
            status.hlta = 1'b1;
        end
    end
endmodule

// File: rtl/bcs_seq_fsm.sv
module bcs_seq_fsm
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              all_rdy,
    input  logic              intr_evt,
    input  logic [DATA_W-1:0] bus_din,
    output cyc_phase_e        phase,
    output cyc_kind_e         kind,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);
    typedef struct packed {
        cyc_phase_e        phase;
        cyc_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } seq_state_t;

    seq_state_t st_d, st_q;
    cyc_kind_e  in_kind;

    assign in_kind = cyc_kind_e'(req_kind);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid && (in_kind != KIND_NONE)) begin
                    st_d.phase = PH_T1;
                    st_d.kind  = in_kind;
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                end
            end
            PH_T1: begin
                st_d.phase = (st_q.kind == KIND_HALT) ? PH_HALT : PH_T2;
            end
            PH_T2, PH_TW: begin
                st_d.phase = all_rdy ? PH_T3 : PH_TW;
            end
            PH_T3: begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
                if (kind_reads(st_q.kind)) begin
                    st_d.rdata = bus_din;
                end
            end
            PH_HALT: begin
                if (intr_evt) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;
    assign kind  = st_q.kind;
    assign addr  = st_q.addr;
    assign wdata = st_q.wdata;
    assign rdata = st_q.rdata;
    assign done  = st_q.done;
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              intr_evt,
    input  logic              bus_rdy,
    input  logic              bus_xrdy,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              psync,
    output logic              pstval_n,
    output logic              pdbin,
    output logic              pwr_n,
    output logic              mwrt,
    output logic              s_memr,
    output logic              s_m1,
    output logic              s_inp,
    output logic              s_out,
    output logic              s_inta,
    output logic              s_hlta,
    output logic              s_wo_n,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int N_RDY = 2;

    cyc_phase_e        phase;
    cyc_kind_e         kind;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic              all_rdy;
    bus_status_t       status;
    logic              rd_strobe;
    logic              wr_strobe;

    bcs_ready_qual #(.N_RDY(N_RDY)) u_rdy (
        .rdy_in  ({bus_xrdy, bus_rdy}),
        .all_rdy (all_rdy)
    );

    bcs_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .all_rdy   (all_rdy),
        .intr_evt  (intr_evt),
        .bus_din   (bus_din),
        .phase     (phase),
        .kind      (kind),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rsp_rdata),
        .done      (rsp_done)
    );

    bcs_status_enc u_enc (
        .phase     (phase),
        .kind      (kind),
        .status    (status),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe)
    );

    assign req_ready = (phase == PH_IDLE);
    assign psync     = (phase == PH_T1);
    assign pstval_n  = !(phase == PH_T1);
    assign pdbin     = rd_strobe;
    assign pwr_n     = !wr_strobe;
    assign bus_addr  = (phase != PH_IDLE) ? addr : '0;
    assign bus_dout  = wr_strobe ? wdata : '0;
    assign s_memr    = status.memr;
    assign s_m1      = status.m1;
    assign s_inp     = status.inp;
    assign s_out     = status.outp;
    assign s_inta    = status.inta;
    assign s_hlta    = status.hlta;
    assign s_wo_n    = !status.wo;
    assign mwrt      = !pwr_n && !s_out;
endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic psync,
    input logic pstval_n,
    input logic pdbin,
    input logic pwr_n,
    input logic mwrt,
    input logic s_memr,
    input logic s_m1,
    input logic s_inp,
    input logic s_out,
    input logic s_inta,
    input logic s_hlta,
    input logic s_wo_n,
    input logic rsp_done
);
    p_sync_single_r2: assert property (@(posedge clk) disable iff (rst)
        psync |=> !psync);

    p_stval_in_sync_r2: assert property (@(posedge clk) disable iff (rst)
        !pstval_n |-> psync);

    p_sync_busy_r2: assert property (@(posedge clk) disable iff (rst)
        psync |-> !req_ready);

    p_status_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({s_memr, s_inp, s_out, s_inta, s_hlta}));

    p_fetch_is_read_r3: assert property (@(posedge clk) disable iff (rst)
        s_m1 |-> s_memr);

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(pdbin && !pwr_n));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    p_mwrt_memory_r7: assert property (@(posedge clk) disable iff (rst)
        mwrt |-> (!s_wo_n && !s_inp && !s_out));

    p_halt_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        (s_hlta && !psync) |-> (!req_ready && !pdbin && pwr_n));
endmodule

bind bus_cycle_seq bus_cycle_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .psync     (psync),
    .pstval_n  (pstval_n),
    .pdbin     (pdbin),
    .pwr_n     (pwr_n),
    .mwrt      (mwrt),
    .s_memr    (s_memr),
    .s_m1      (s_m1),
    .s_inp     (s_inp),
    .s_out     (s_out),
    .s_inta    (s_inta),
    .s_hlta    (s_hlta),
    .s_wo_n    (s_wo_n),
    .rsp_done  (rsp_done)
);

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [2:0]    req_kind = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          intr_evt = 1'b0;
    logic          bus_rdy = 1'b1;
    logic          bus_xrdy = 1'b1;
    logic [DW-1:0] bus_din = '0;
    logic          req_ready, psync, pstval_n, pdbin, pwr_n, mwrt;
    logic          s_memr, s_m1, s_inp, s_out, s_inta, s_hlta, s_wo_n, rsp_done;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_dout, rsp_rdata;

    always #5 clk = !clk;

    bus_cycle_seq #(.ADDR_W(AW), .DATA_W(DW)) u_bus_cycle_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .intr_evt(intr_evt), .bus_rdy(bus_rdy), .bus_xrdy(bus_xrdy),
        .bus_din(bus_din), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .psync(psync), .pstval_n(pstval_n), .pdbin(pdbin), .pwr_n(pwr_n),
        .mwrt(mwrt), .s_memr(s_memr), .s_m1(s_m1), .s_inp(s_inp),
        .s_out(s_out), .s_inta(s_inta), .s_hlta(s_hlta), .s_wo_n(s_wo_n),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
    );

    // Reference model. Stages: 0 idle, 1 start, 2 strobe, 4 waiting, 3 closing, 5 halted.
    int            m_st = 0;
    int            m_kind = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wdata = '0;
    logic [DW-1:0] m_rdata = '0;
    bit            m_done = 0;
    bit            m_tag_b2b = 0;
    bit            m_tag_bogus = 0;
    bit            m_in_reset = 1;

    function automatic bit reads(int k);
        return k == 0 || k == 1 || k == 3 || k == 5;
    endfunction

    function automatic bit writes(int k);
        return k == 2 || k == 4;
    endfunction

    always @(posedge clk) begin
        m_tag_b2b   = 0;
        m_tag_bogus = 0;
        if (rst) begin
            m_st = 0; m_kind = 0; m_addr = '0; m_wdata = '0; m_rdata = '0;
            m_done = 0; m_in_reset = 1;
        end else begin
            bit was_done;
            was_done   = m_done;
            m_done     = 0;
            m_in_reset = 0;
            if (m_st == 0) begin
                if (req_valid && req_kind != 3'd7) begin
                    m_st = 1; m_kind = int'(req_kind); m_addr = req_addr; m_wdata = req_wdata;
                    m_tag_b2b = was_done;
                end else if (req_valid) begin
                    m_tag_bogus = 1;
                end
            end else if (m_st == 1) begin
                m_st = (m_kind == 6) ? 5 : 2;
            end else if (m_st == 2 || m_st == 4) begin
                m_st = (bus_rdy && bus_xrdy) ? 3 : 4;
            end else if (m_st == 3) begin
                if (reads(m_kind)) m_rdata = bus_din;
                m_done = 1;
                m_st   = 0;
            end else if (m_st == 5) begin
                if (intr_evt) begin
                    m_done = 1;
                    m_st   = 0;
                end
            end
        end
    end

    int vectors = 0;
    int misses  = 0;

    task automatic chk(string tag, string name, longint act, longint exp);
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, name, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit    busy, strobe;
        string t_rst, t_sync, t_str, t_done;
        busy   = (m_st >= 1 && m_st <= 4);
        strobe = (m_st == 2 || m_st == 3 || m_st == 4);
        t_rst  = m_in_reset ? "R1" : "R2";
        t_sync = m_tag_b2b ? "R10" : (m_tag_bogus ? "R9" : t_rst);
        t_str  = (m_st == 4) ? "R5" : (m_in_reset ? "R1" : "R4");
        t_done = m_tag_bogus ? "R9" : (m_in_reset ? "R1" : "R6");
        vectors++;
        chk(t_sync, "psync", psync, m_st == 1);
        chk(t_sync, "pstval_n", pstval_n, m_st != 1);
        chk(m_tag_bogus ? "R9" : t_rst, "req_ready", req_ready, m_st == 0);
        chk(t_rst, "bus_addr", bus_addr, (m_st != 0) ? m_addr : '0);
        chk(t_str, "pdbin", pdbin, strobe && reads(m_kind));
        chk(t_str, "pwr_n", pwr_n, !(strobe && writes(m_kind)));
        chk(t_str, "bus_dout", bus_dout, (strobe && writes(m_kind)) ? m_wdata : '0);
        chk(m_in_reset ? "R1" : "R7", "mwrt", mwrt, strobe && m_kind == 2);
        chk(m_in_reset ? "R1" : "R3", "s_memr", s_memr, busy && (m_kind == 0 || m_kind == 1));
        chk(m_in_reset ? "R1" : "R3", "s_m1", s_m1, busy && m_kind == 1);
        chk(m_in_reset ? "R1" : "R3", "s_inp", s_inp, busy && m_kind == 3);
        chk(m_in_reset ? "R1" : "R3", "s_out", s_out, busy && m_kind == 4);
        chk(m_in_reset ? "R1" : "R3", "s_inta", s_inta, busy && m_kind == 5);
        chk(m_in_reset ? "R1" : "R3", "s_wo_n", s_wo_n, !(busy && writes(m_kind)));
        chk(m_in_reset ? "R1" : "R8", "s_hlta", s_hlta, (m_st == 1 && m_kind == 6) || m_st == 5);
        chk(t_done, "rsp_done", rsp_done, m_done);
        chk(t_done, "rsp_rdata", rsp_rdata, m_rdata);
    endtask

    typedef struct {
        int            kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        int            waits;
        int            gap;
    } txn_t;

    txn_t q[$];

    task automatic add(int k, int a, int d, int w, int g);
        txn_t t;
        t.kind = k; t.addr = AW'(a); t.wdata = DW'(d); t.waits = w; t.gap = g;
        q.push_back(t);
    endtask

    initial begin
        int  wait_left = 0;
        int  halt_left = 0;
        int  gap_left  = 0;
        int  cyc       = 0;
        int  idle_run  = 0;
        bit  timed_out = 0;

        // R1..R10 stimulus: every kind, wait counts, gaps and back-to-back issue
        add(0, 'h1234, 0, 0, 0);
        add(1, 'h0100, 0, 1, 0);
        add(2, 'h8000, 'hA5, 0, 0);   // memory write: mwrt expected (R7)
        add(4, 'h00FE, 'h3C, 2, 0);   // I/O write: no mwrt (R7)
        add(3, 'h0042, 0, 3, 2);
        add(7, 'h5555, 'hFF, 0, 0);   // ignored kind (R9)
        add(5, 'h0000, 0, 1, 0);
        add(6, 'h0077, 0, 4, 0);      // halt, released by intr after a delay (R8)
        add(2, 'hFFFF, 'h81, 5, 0);
        add(0, 'hABCD, 0, 0, 0);      // back-to-back after write (R10)
        add(7, 'h1111, 'h11, 0, 1);
        add(1, 'h2222, 0, 0, 0);
        add(4, 'h0001, 'h7E, 0, 0);
        add(3, 'h0002, 0, 0, 0);
        add(6, 'h0003, 0, 0, 0);
        add(5, 'h0004, 0, 6, 0);
        add(0, 'h0005, 0, 2, 3);

        repeat (3) begin
            @(negedge clk);
            compare_all();           // R1 reset state
        end
        rst = 1'b0;

        forever begin
            @(negedge clk);
            cyc++;
            compare_all();
            req_valid = 1'b0;
            intr_evt  = 1'b0;
            bus_rdy   = 1'b1;
            bus_xrdy  = 1'b1;
            bus_din   = DW'(cyc * 37 + 5);
            if (m_st == 0 && q.size() > 0) begin
                if (gap_left > 0) begin
                    gap_left--;
                end else begin
                    txn_t t;
                    t = q.pop_front();
                    req_valid = 1'b1;
                    req_kind  = 3'(t.kind);
                    req_addr  = t.addr;
                    req_wdata = t.wdata;
                    wait_left = t.waits;
                    halt_left = t.waits;
                    gap_left  = (q.size() > 0) ? q[0].gap : 0;
                end
            end else if (m_st == 2 || m_st == 4) begin
                intr_evt = 1'b1;     // outside halt, must change nothing (R8)
                if (wait_left > 0) begin
                    if (wait_left % 2 == 1) bus_xrdy = 1'b0;
                    else bus_rdy = 1'b0;
                    wait_left--;
                end
            end else if (m_st == 1 || m_st == 3) begin
                bus_rdy  = 1'b0;     // ready ignored outside the sampling clocks (R5)
                bus_xrdy = 1'b0;
            end else if (m_st == 5) begin
                if (halt_left > 0) halt_left--;
                else intr_evt = 1'b1;
            end
            idle_run = (m_st == 0 && q.size() == 0) ? idle_run + 1 : 0;
            if (idle_run > 4) break;
            if (cyc > 5000) begin
                timed_out = 1;
                break;
            end
        end
        if (timed_out) begin
            misses++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule